// File: doc/BRIEF.md
# Host Port Request Generator

This block sits on the host side of a parallel host port. It holds three control bits, a one-word receive register that the processor side fills, and a one-word transmit register that the host fills. A status flag goes with each register: receive-full and transmit-empty. From these it drives two host request pins.

The two pins have two roles, chosen by a control bit. In combined mode, pin A is one active-low request for either direction. Pin B is then an acknowledge input, and its output driver is released. In split mode, pin A requests only transmit service and pin B requests only receive service. When a direction's enable is clear, that direction raises no request and the host polls the status word instead.

The host makes single-cycle accesses with a select, a write strobe and a two-bit address. Read data is combinational from the current register state. Every register effect of an access takes place at the clock edge that ends the access cycle.

Top module: `hostreq_top`

## Requirements
- R1: After a synchronous active-low reset the outputs and registers are as follows. All three control bits are 0 and receive-full is 0. Transmit-empty is 1. `req_a_n` and `req_b_n` are 1, `req_b_oe` is 0 and `ack_seen` is 0.
- R2: A host write to address 0 stores `host_wdata[2:0]` as the control bits: bit 0 is the receive enable, bit 1 is the transmit enable and bit 2 is the split-mode select. A read of address 0 returns those bits, with all higher bits 0.
- R3: Receive-full becomes 1 at the edge where `cpu_rx_load` is high. It becomes 0 at the edge that ends a host read of address 2. If both happen in the same cycle, the load wins and the flag stays 1.
- R4: Transmit-empty becomes 0 at the edge that ends a host write to address 2. It becomes 1 at the edge where `cpu_tx_take` is high. If both happen in the same cycle, the write wins and the flag is 0. `cpu_tx_data` always shows the word last written by the host.
- R5: In combined mode (bit 2 = 0), `req_a_n` is 0 exactly when (receive-full AND receive enable) OR (transmit-empty AND transmit enable) held in the previous cycle.
- R6: In combined mode, `req_b_oe` is 0 and `req_b_n` is 1 one cycle later. `ack_seen` is 1 exactly when `req_b_in_n` was 0 in the previous cycle.
- R7: In split mode (bit 2 = 1), one cycle later `req_b_oe` is 1 and `ack_seen` is 0. `req_a_n` is 0 exactly when transmit-empty AND transmit enable held in the previous cycle. `req_b_n` is 0 exactly when receive-full AND receive enable held in the previous cycle.
- R8: With a direction's enable at 0, that direction's flag never causes a request on either pin, so a pin whose only source is disabled stays at 1.
- R9: A host read of address 1 returns receive-full in bit 0 and transmit-empty in bit 1, with higher bits 0, and changes no flag.
- R10: A host read of address 2 returns the word last loaded by `cpu_rx_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access in this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 control, 1 status, 2 data |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational) |
| cpu_rx_load | input | 1 | Processor side loads receive word |
| cpu_rx_data | input | DATA_W | Word loaded into receive register |
| cpu_tx_take | input | 1 | Processor side takes transmit word |
| cpu_tx_data | output | DATA_W | Current transmit register word |
| req_a_n | output | 1 | Pin A: combined request or transmit request, active low |
| req_b_n | output | 1 | Pin B output value: receive request, active low |
| req_b_oe | output | 1 | Pin B output driver enable |
| req_b_in_n | input | 1 | Pin B input value, acknowledge in combined mode |
| ack_seen | output | 1 | Registered acknowledge, combined mode only |

## Verification
Two pairs of events can fall in the same cycle, and each pair has a set priority. A processor load and a host read of the receive register can coincide. A host write and a processor take of the transmit register can also coincide. Directed steps drive each pair in one cycle. The random phase lets them collide freely, with the loads, takes and accesses each drawn at high rates. A bench model applies the stated priority and predicts the flag. A following status read and the next cycle's request pins then show whether the flag, and the returned word, came out as the model predicts.

// File: rtl/hostreq_pkg.sv
// Package: shared address codes and control-register layout for the host
// port request generator. Assumes a two-bit host address.
package hostreq_pkg;

    localparam int CTRL_W = 3;
    localparam int STAT_W = 2;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } haddr_e;

    // bit 2 split mode, bit 1 transmit enable, bit 0 receive enable
    typedef struct packed {
        logic split;
        logic tx_en;
        logic rx_en;
    } ctrl_t;

endpackage

// File: rtl/hostreq_ctrl.sv
// Module: control register. Holds the receive enable, transmit enable and
// split-mode bits. Assumes a write strobe qualified by the host decoder.
module hostreq_ctrl
    import hostreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_bits,
    output ctrl_t             ctrl
);

    // Load control bits on a host write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en)
            ctrl <= ctrl_t'(wr_bits);
    end

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl == $past(wr_bits)));

endmodule

// File: rtl/hostreq_data.sv
// Module: receive and transmit data registers with their status flags.
// Assumes at most one host access per cycle. A processor load beats a
// host read, and a host write beats a processor take.
module hostreq_data #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_load_data,
    input  logic              rx_read,
    input  logic              tx_write,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_take,
    input  logic              stat_read,
    output logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] tx_data,
    output logic              rx_full,
    output logic              tx_empty
);

    // Receive word and full flag: load sets, host read clears, load wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else begin
            if (rx_load) begin
                rx_data <= rx_load_data;
                rx_full <= 1'b1;
            end else if (rx_read) begin
                rx_full <= 1'b0;
            end
        end
    end

    // Transmit word and empty flag: host write clears, take sets, write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_empty <= 1'b1;
        end else begin
            if (tx_write) begin
                tx_data  <= tx_wdata;
                tx_empty <= 1'b0;
            end else if (tx_take) begin
                tx_empty <= 1'b1;
            end
        end
    end

    assert_rx_full_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> rx_full);

    assert_tx_empty_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> !tx_empty);

    assert_status_pure_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && !rx_load && !tx_take) |=> ($stable(rx_full) && $stable(tx_empty)));

endmodule

// File: rtl/hostreq_pins.sv
// Module: request pin generator. Registers the active-low requests from
// the flags and enables, and switches pin B between an acknowledge input
// and a receive request output according to the split-mode bit.
module hostreq_pins
    import hostreq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  rx_full,
    input  logic  tx_empty,
    input  logic  pin_b_in_n,
    output logic  req_a_n,
    output logic  req_b_n,
    output logic  req_b_oe,
    output logic  ack_seen
);

    logic rx_want;
    logic tx_want;
    logic a_next_n;
    logic b_next_n;

    // Per-direction service wishes gated by their enables.
    always_comb begin
        rx_want = rx_full  && ctrl.rx_en;
        tx_want = tx_empty && ctrl.tx_en;
    end

    // Route the wishes to the pins according to the mode bit.
    always_comb begin
        if (ctrl.split) begin
            a_next_n = !tx_want;
            b_next_n = !rx_want;
        end else begin
            a_next_n = !(rx_want || tx_want);
            b_next_n = 1'b1;
        end
    end

    // Register pin values, driver enable and acknowledge capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_a_n  <= 1'b1;
            req_b_n  <= 1'b1;
            req_b_oe <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            req_a_n  <= a_next_n;
            req_b_n  <= b_next_n;
            req_b_oe <= ctrl.split;
            ack_seen <= !ctrl.split && !pin_b_in_n;
        end
    end

    assert_b_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.split |=> (!req_b_oe && req_b_n));

    assert_tx_pin_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.split && !ctrl.tx_en) |=> req_a_n);

    assert_split_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.split |=> (req_b_oe && !ack_seen));

    assert_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.rx_en && !ctrl.tx_en) |=> (req_a_n && req_b_n));

endmodule

// File: rtl/hostreq_top.sv
// Module: host port request generator top. Decodes single-cycle host
// accesses, muxes read data, and links the control, data and pin blocks.
// Assumes DATA_W is at least CTRL_W bits wide.
module hostreq_top
    import hostreq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cpu_rx_load,
    input  logic [DATA_W-1:0] cpu_rx_data,
    input  logic              cpu_tx_take,
    output logic [DATA_W-1:0] cpu_tx_data,
    output logic              req_a_n,
    output logic              req_b_n,
    output logic              req_b_oe,
    input  logic              req_b_in_n,
    output logic              ack_seen
);

    localparam int CTRL_PAD = DATA_W - CTRL_W;
    localparam int STAT_PAD = DATA_W - STAT_W;

    haddr_e            addr;
    logic              ctrl_wr;
    logic              stat_rd;
    logic              data_rd;
    logic              data_wr;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] rx_word;
    logic              rx_full;
    logic              tx_empty;

    // Decode the host access into per-register strobes.
    always_comb begin
        addr    = haddr_e'(host_addr);
        ctrl_wr = host_sel &&  host_wr && (addr == ADDR_CTRL);
        stat_rd = host_sel && !host_wr && (addr == ADDR_STAT);
        data_rd = host_sel && !host_wr && (addr == ADDR_DATA);
        data_wr = host_sel &&  host_wr && (addr == ADDR_DATA);
    end

    // Select the read word from the addressed register.
    always_comb begin
        case (addr)
            ADDR_CTRL: host_rdata = {{CTRL_PAD{1'b0}}, ctrl};
            ADDR_STAT: host_rdata = {{STAT_PAD{1'b0}}, tx_empty, rx_full};
            ADDR_DATA: host_rdata = rx_word;
            default:   host_rdata = '0;
        endcase
    end

    hostreq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_bits (host_wdata[CTRL_W-1:0]),
        .ctrl    (ctrl)
    );

    hostreq_data #(.DATA_W(DATA_W)) u_data (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_load      (cpu_rx_load),
        .rx_load_data (cpu_rx_data),
        .rx_read      (data_rd),
        .tx_write     (data_wr),
        .tx_wdata     (host_wdata),
        .tx_take      (cpu_tx_take),
        .stat_read    (stat_rd),
        .rx_data      (rx_word),
        .tx_data      (cpu_tx_data),
        .rx_full      (rx_full),
        .tx_empty     (tx_empty)
    );

    hostreq_pins u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .rx_full    (rx_full),
        .tx_empty   (tx_empty),
        .pin_b_in_n (req_b_in_n),
        .req_a_n    (req_a_n),
        .req_b_n    (req_b_n),
        .req_b_oe   (req_b_oe),
        .ack_seen   (ack_seen)
    );

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rx_load && data_rd) |=> rx_full);

    assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cpu_tx_take) |=> !tx_empty);

endmodule

// File: tb/hostreq_top_tb.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a cycle model kept in bench variables.
module hostreq_top_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         host_sel, host_wr;
    logic [1:0]   host_addr;
    logic [W-1:0] host_wdata, host_rdata;
    logic         cpu_rx_load, cpu_tx_take;
    logic [W-1:0] cpu_rx_data, cpu_tx_data;
    logic         req_a_n, req_b_n, req_b_oe, req_b_in_n, ack_seen;

    int n_total = 0;
    int n_fail  = 0;

    // model state
    logic [2:0]   m_ctrl;
    logic         m_rxf, m_txe;
    logic [W-1:0] m_rxd, m_txd;

    always #2 clk = ~clk;

    hostreq_top #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cpu_rx_load(cpu_rx_load), .cpu_rx_data(cpu_rx_data),
        .cpu_tx_take(cpu_tx_take), .cpu_tx_data(cpu_tx_data),
        .req_a_n(req_a_n), .req_b_n(req_b_n), .req_b_oe(req_b_oe),
        .req_b_in_n(req_b_in_n), .ack_seen(ack_seen)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {{(W-3){1'b0}}, m_ctrl};
            2'd1: return {{(W-2){1'b0}}, m_txe, m_rxf};
            2'd2: return m_rxd;
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_a_n();
        logic rw = m_rxf & m_ctrl[0];
        logic tw = m_txe & m_ctrl[1];
        return m_ctrl[2] ? !tw : !(rw | tw);
    endfunction

    function automatic logic exp_b_n();
        return m_ctrl[2] ? !(m_rxf & m_ctrl[0]) : 1'b1;
    endfunction

    // One host/processor cycle with full checking of the result.
    task automatic step(input logic sel, input logic wr, input logic [1:0] addr,
                        input logic [W-1:0] wd, input logic ld, input logic [W-1:0] ldd,
                        input logic tk, input logic ackn);
        logic ea, eb, eoe, eack;
        string rtag;
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_addr = addr; host_wdata = wd;
        cpu_rx_load = ld; cpu_rx_data = ldd; cpu_tx_take = tk; req_b_in_n = ackn;
        #1;
        if (sel && !wr) begin
            rtag = (addr == 2'd0) ? "R2" : (addr == 2'd1) ? "R9" : (addr == 2'd2) ? "R10" : "R9";
            chk(rtag, host_rdata, exp_read(addr));
        end
        ea   = exp_a_n();
        eb   = exp_b_n();
        eoe  = m_ctrl[2];
        eack = !m_ctrl[2] && !ackn;
        // model update with stated priorities
        if (ld) begin m_rxf = 1'b1; m_rxd = ldd; end
        else if (sel && !wr && addr == 2'd2) m_rxf = 1'b0;
        if (sel && wr && addr == 2'd2) begin m_txe = 1'b0; m_txd = wd; end
        else if (tk) m_txe = 1'b1;
        if (sel && wr && addr == 2'd0) m_ctrl = wd[2:0];
        @(posedge clk);
        #1;
        if (!eoe) begin
            chk(((!m_ctrl[0] && !m_ctrl[1]) ? "R8" : "R5"), req_a_n, ea);
            chk("R6", req_b_oe, 1'b0);
            chk("R6", req_b_n, 1'b1);
            chk("R6", ack_seen, eack);
        end else begin
            chk("R7", req_a_n, ea);
            chk("R7", req_b_n, eb);
            chk("R7", req_b_oe, 1'b1);
            chk("R7", ack_seen, 1'b0);
        end
        chk("R4", cpu_tx_data, m_txd);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'd3, '0, 1'b0, '0, 1'b0, 1'b1);
    endtask

    task automatic rd(input logic [1:0] a);
        step(1'b1, 1'b0, a, '0, 1'b0, '0, 1'b0, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        n_total++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c0d));
        rst_n = 1'b0;
        host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
        cpu_rx_load = 0; cpu_rx_data = 0; cpu_tx_take = 0; req_b_in_n = 1;
        m_ctrl = 0; m_rxf = 0; m_txe = 1; m_rxd = 0; m_txd = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", req_a_n, 1'b1);
        chk("R1", req_b_n, 1'b1);
        chk("R1", req_b_oe, 1'b0);
        chk("R1", ack_seen, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0);
        rd(2'd1);

        // R8: no enables, flags active, no request
        step(1'b0, 1'b0, 2'd0, '0, 1'b1, 8'hA5, 1'b0, 1'b1);
        idle();
        // R2: control write and readback with upper bits ignored
        step(1'b1, 1'b1, 2'd0, 8'hF9, 1'b0, '0, 1'b0, 1'b1);
        rd(2'd0);
        // R5 combined with receive enable; R6 acknowledge capture
        step(1'b0, 1'b0, 2'd0, '0, 1'b0, '0, 1'b0, 1'b0);
        idle();
        // R3: load and host read of receive word in the same cycle
        step(1'b1, 1'b0, 2'd2, '0, 1'b1, 8'h3C, 1'b0, 1'b1);
        rd(2'd1);
        rd(2'd2);
        rd(2'd1);
        // R4: host write and processor take in the same cycle
        step(1'b1, 1'b1, 2'd2, 8'h77, 1'b0, '0, 1'b1, 1'b1);
        rd(2'd1);
        step(1'b0, 1'b0, 2'd0, '0, 1'b0, '0, 1'b1, 1'b1);
        // R7: split mode with only transmit enable
        step(1'b1, 1'b1, 2'd0, 8'h06, 1'b0, '0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 2'd0, '0, 1'b1, 8'h11, 1'b0, 1'b0);
        idle();
        // R7: split mode with only receive enable
        step(1'b1, 1'b1, 2'd0, 8'h05, 1'b0, '0, 1'b0, 1'b1);
        idle();
        idle();

        for (int i = 0; i < 4000; i++) begin
            logic sel = ($urandom % 4) != 0;
            logic wr  = $urandom % 2;
            logic [1:0] a = $urandom % 4;
            if (wr && a == 2'd0 && ($urandom % 4) != 0) a = 2'd2;
            step(sel, wr, a, W'($urandom), ($urandom % 3) == 0, W'($urandom),
                 ($urandom % 3) == 0, $urandom % 2);
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule